// File: doc/BRIEF.md
# Queued Asynchronous Serial Transmitter

This block sends characters over an asynchronous serial line. Characters of nine bits (eight data bits and a ninth bit) are written into a transmit queue. The queue holds up to `DEPTH` characters. A framing state machine takes the oldest queued character into a nine-bit shift register. It then sends one bit of the frame per baud tick: a low start bit, the eight data bits least significant first, the ninth bit, and one or two high stop bits. The baud tick comes from outside the block. The serial line idles high.

The queue has two modes. With `fifo_on` high it is a first-in first-out buffer that drops writes when it is full. With `fifo_on` low it acts as a single holding slot, and a write to a full slot replaces the character in it. The ninth bit is either the stored bit or a parity bit computed from the data, with the parity sense selectable. The block samples the frame settings when it loads each character. A clear strobe discards everything queued. A character already in the shift register is not affected by the clear.

The framer has seven states, each named in `txq_pkg`:
- `TX_IDLE`: the shift register is empty.
- `TX_ARMED`: a character is loaded and waits for the next tick.
- `TX_START`, `TX_DATA`, `TX_NINTH`, `TX_STOP1`, `TX_STOP2`: one state for each part of the frame.

The transitions are:
- IDLE→ARMED when the queue is not empty. This step also pops the queue.
- ARMED→START on a tick.
- START→DATA on a tick.
- DATA→DATA on a tick while data bits remain.
- DATA→NINTH on the tick after the last data bit.
- NINTH→STOP1 on a tick.
- STOP1→STOP2 on a tick when two stop bits are selected.
- From the last stop state on a tick: →START if the queue holds a character (this step also pops the queue), otherwise →IDLE.

Top module: `serial_tx_unit`

## Requirements
- R1: After reset, `txd` is 1, `empty` is 1, `full` is 0 and `half_empty` is 1.
- R2: With `fifo_on`=1, `full` is 1 exactly when the queue holds `DEPTH` characters. A write while full is dropped, and no queued character changes.
- R3: With `fifo_on`=0, `full` is 1 whenever the queue holds a character. A write while full replaces the newest queued character, and the count stays the same.
- R4: With `fifo_on`=1, `half_empty` is 1 when the count is at most `DEPTH`/2. With `fifo_on`=0, `half_empty` is 1 only when the queue is empty.
- R5: A cycle with `fifo_clr`=1 leaves the queue empty on the next cycle. Discarded characters are never sent.
- R6: A frame is: start bit 0, then `wr_data[0]` to `wr_data[7]`, then the ninth bit, then stop bits of 1. `txd` changes only on cycles after a `baud_tick`.
- R7: With `par_mode`=0, the ninth bit is `wr_data[8]`. With `par_mode`=1, `wr_data[8]` is ignored. The ninth bit is then the XOR of the eight data bits when `par_odd`=0, and its inverse when `par_odd`=1.
- R8: With `two_stop`=0 a frame has one stop bit. With `two_stop`=1 it has two.
- R9: A write to an empty queue while the framer is idle loads the shift register within two cycles. `txd` stays 1 until the next `baud_tick`, and the start bit is driven on the cycle after that tick.
- R10: When a frame's last stop bit ends and the queue is not empty, the next start bit follows on that same tick, with no idle bit between frames.
- R11: Characters are sent oldest first. The framer pops only when the queue is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | DATA_W+1 | Character: data in [7:0], ninth bit in [8] |
| fifo_clr | input | 1 | Discards all queued characters |
| fifo_on | input | 1 | 1: queue mode, 0: single overwritable slot |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| par_mode | input | 1 | 1: ninth bit is parity, 0: ninth bit is the stored bit |
| par_odd | input | 1 | Parity sense when `par_mode`=1 (1 = odd) |
| two_stop | input | 1 | 1: two stop bits, 0: one stop bit |
| txd | output | 1 | Serial line, idles high |
| full | output | 1 | Queue full for the current mode |
| half_empty | output | 1 | Half-empty status for the current mode |
| empty | output | 1 | Queue holds no character |

## Verification
The bench builds the block with `DEPTH`=4. With that depth, the full and dropped-write cases and the half-empty threshold of 2 are reached in a handful of writes, so every queue count from 0 to full is checked against the status bits. At that size the bench also sweeps all 256 data values under both parity senses. For each frame it computes the expected bit sequence arithmetically and compares it bit by bit with the line sampled after each tick. Separate runs cover back-to-back frames with one and two stop bits, overwriting in slot mode, and clearing the queue during a frame.

// File: rtl/txq_pkg.sv
package txq_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_ARMED,
        TX_START,
        TX_DATA,
        TX_NINTH,
        TX_STOP1,
        TX_STOP2
    } tx_state_e;

    typedef struct packed {
        logic par_mode;
        logic par_odd;
        logic two_stop;
    } frame_cfg_t;

endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int DEPTH  = 16,
    parameter int CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fifo_on,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              pop,
    output logic [CHAR_W-1:0] rd_data,
    output logic              full,
    output logic              half_empty,
    output logic              empty
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int HALF = DEPTH / 2;

    logic [CHAR_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr, last_ptr;
    logic [CW-1:0]     count;
    logic              full_c, push, ovw, pop_ok;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        full_c   = fifo_on ? (count == CW'(DEPTH)) : (count != '0);
        pop_ok   = pop && !clr && (count != '0);
        // slot mode: a pop in the same cycle frees the slot, so append instead
        push     = wr_en && !clr && (!full_c || (!fifo_on && pop_ok));
        ovw      = wr_en && !clr && !fifo_on && full_c && !pop_ok;
        last_ptr = (wr_ptr == '0) ? AW'(DEPTH - 1) : wr_ptr - AW'(1);
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wr_data;
        end else if (ovw) begin
            mem[last_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)   wr_ptr <= ptr_inc(wr_ptr);
            if (pop_ok) rd_ptr <= ptr_inc(rd_ptr);
            count <= count + CW'(push) - CW'(pop_ok);
        end
    end

    always_comb begin
        rd_data    = mem[rd_ptr];
        full       = full_c;
        empty      = (count == '0);
        half_empty = fifo_on ? (count <= CW'(HALF)) : (count == '0);
    end

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_on && full_c && wr_en && !clr) |=> (count == $past(count) - CW'($past(pop_ok))));

    p_overwrite_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_on && full_c && wr_en && !pop && !clr) |=> (count == $past(count) && !empty));

    p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);

    p_pop_nonempty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/txq_framer.sv
module txq_framer
    import txq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            avail,
    input  logic [DATA_W:0] rd_data,
    input  frame_cfg_t      cfg,
    output logic            pop,
    output logic            txd
);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    tx_state_e       state, nxt;
    logic [DATA_W:0] shreg;
    logic [BW-1:0]   bitcnt;
    logic            two_q;
    logic            last_stop, load, ninth;

    always_comb begin
        last_stop = (state == TX_STOP2) || (state == TX_STOP1 && !two_q);
        load      = avail && ((state == TX_IDLE) || (tick && last_stop));
        ninth     = cfg.par_mode ? ((^rd_data[DATA_W-1:0]) ^ cfg.par_odd)
                                 : rd_data[DATA_W];
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (avail) nxt = TX_ARMED;
            TX_ARMED: if (tick)  nxt = TX_START;
            TX_START: if (tick)  nxt = TX_DATA;
            TX_DATA:  if (tick && bitcnt == BW'(DATA_W - 1)) nxt = TX_NINTH;
            TX_NINTH: if (tick)  nxt = TX_STOP1;
            TX_STOP1: if (tick) begin
                if (two_q)      nxt = TX_STOP2;
                else if (avail) nxt = TX_START;
                else            nxt = TX_IDLE;
            end
            TX_STOP2: if (tick)  nxt = avail ? TX_START : TX_IDLE;
            default:             nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= TX_IDLE;
            shreg  <= '1;
            bitcnt <= '0;
            two_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (load) begin
                shreg <= {ninth, rd_data[DATA_W-1:0]};
                two_q <= cfg.two_stop;
            end else if (tick && state == TX_DATA) begin
                shreg <= {1'b1, shreg[DATA_W:1]};
            end
            if (tick && state == TX_START)     bitcnt <= '0;
            else if (tick && state == TX_DATA) bitcnt <= bitcnt + BW'(1);
        end
    end

    always_comb begin
        pop = load;
        unique case (state)
            TX_START:          txd = 1'b0;
            TX_DATA, TX_NINTH: txd = shreg[0];
            default:           txd = 1'b1;
        endcase
    end

    p_line_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(txd));

    p_start_after_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_ARMED && tick) |=> (txd == 1'b0));

    p_ninth_then_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_NINTH && tick) |=> txd);

    p_chain_frames_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && last_stop && avail) |=> (state == TX_START && !txd));

endmodule

// File: rtl/serial_tx_unit.sv
module serial_tx_unit
    import txq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DATA_W:0] wr_data,
    input  logic            fifo_clr,
    input  logic            fifo_on,
    input  logic            baud_tick,
    input  logic            par_mode,
    input  logic            par_odd,
    input  logic            two_stop,
    output logic            txd,
    output logic            full,
    output logic            half_empty,
    output logic            empty
);
    localparam int CHAR_W = DATA_W + 1;

    logic [DATA_W:0] head;
    logic            pop, avail, q_empty;
    frame_cfg_t      cfg;

    always_comb begin
        cfg.par_mode = par_mode;
        cfg.par_odd  = par_odd;
        cfg.two_stop = two_stop;
        avail        = !q_empty && !fifo_clr;
        empty        = q_empty;
    end

    txq_store #(.DEPTH(DEPTH), .CHAR_W(CHAR_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .fifo_on    (fifo_on),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .pop        (pop),
        .rd_data    (head),
        .full       (full),
        .half_empty (half_empty),
        .empty      (q_empty)
    );

    txq_framer #(.DATA_W(DATA_W)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .avail   (avail),
        .rd_data (head),
        .cfg     (cfg),
        .pop     (pop),
        .txd     (txd)
    );

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (txd && empty && !full && half_empty));

endmodule

// File: tb/sim_serial_tx_unit.sv
module sim_serial_tx_unit;
    localparam int DEPTH = 4;
    localparam int TG    = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       fifo_clr = 1'b0;
    logic       fifo_on = 1'b1;
    logic       baud_tick = 1'b0;
    logic       par_mode = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       txd, full, half_empty, empty;

    int checks = 0;
    int errors = 0;
    int tick_cnt = 0;
    bit line_q[$];
    bit exp_q[$];

    always #10 clk = ~clk;

    serial_tx_unit #(.DEPTH(DEPTH), .DATA_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_clr(fifo_clr), .fifo_on(fifo_on), .baud_tick(baud_tick),
        .par_mode(par_mode), .par_odd(par_odd), .two_stop(two_stop),
        .txd(txd), .full(full), .half_empty(half_empty), .empty(empty)
    );

    // tick source; the line is recorded one half cycle after each tick edge
    initial begin
        forever begin
            repeat (TG - 1) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
            line_q.push_back(txd);
            tick_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic status(input string req, input bit f, input bit h, input bit e);
        chk({full, half_empty, empty} == {f, h, e}, req,
            int'({full, half_empty, empty}), int'({f, h, e}));
    endtask

    function automatic void add_frame(input logic [8:0] v, input bit pm,
                                      input bit po, input bit ts);
        exp_q.push_back(1'b0);
        for (int i = 0; i < 8; i++) exp_q.push_back(v[i]);
        exp_q.push_back(pm ? ((^v[7:0]) ^ po) : v[8]);
        exp_q.push_back(1'b1);
        if (ts) exp_q.push_back(1'b1);
    endfunction

    function automatic void add_idle(input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(1'b1);
    endfunction

    task automatic put(input logic [8:0] v);
        @(posedge clk); #4;
        wr_en = 1'b1; wr_data = v;
        @(posedge clk); #4;
        wr_en = 1'b0;
    endtask

    task automatic check_stream(input string req);
        int first = -1;
        int n = exp_q.size();
        int cyc = 0;
        bit ok = 1'b1;
        int bad_i = 0;
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
            first = -1;
            for (int i = 0; i < line_q.size(); i++) begin
                if (line_q[i] == 1'b0) begin first = i; break; end
            end
            if (first >= 0 && line_q.size() >= first + n) break;
        end
        if (first < 0 || line_q.size() < first + n) begin
            chk(1'b0, req, line_q.size(), n);
        end else begin
            for (int i = 0; i < n; i++) begin
                if (line_q[first + i] != exp_q[i] && ok) begin ok = 1'b0; bad_i = i; end
            end
            chk(ok, req, ok ? 0 : int'(line_q[first + bad_i]),
                ok ? 0 : int'(exp_q[bad_i]));
        end
        exp_q.delete();
        repeat (3 * TG) @(posedge clk);
        #4;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #4 rst_n = 1'b1;
        // R1 reset state
        chk(txd == 1'b1, "R1 txd", int'(txd), 1);
        status("R1 status", 1'b0, 1'b1, 1'b1);

        // R9 exact timing from idle, stored ninth bit (R7, R6)
        begin
            int t = tick_cnt;
            wait (tick_cnt != t);
            line_q.delete();
            put(9'h1A5);
            repeat (2) @(posedge clk);
            #4;
            chk(txd == 1'b1, "R9 high before tick", int'(txd), 1);
            wait (line_q.size() >= 1);
            chk(line_q[0] == 1'b0, "R9 start on first tick", int'(line_q[0]), 0);
            add_frame(9'h1A5, 1'b0, 1'b0, 1'b0);
            check_stream("R6 R7 stored ninth one");
        end
        line_q.delete();
        put(9'h03C);
        add_frame(9'h03C, 1'b0, 1'b0, 1'b0);
        check_stream("R7 stored ninth zero");

        // R7 parity sweep over all data values and both senses
        par_mode = 1'b1;
        for (int s = 0; s < 2; s++) begin
            par_odd = s[0];
            for (int d = 0; d < 256; d++) begin
                logic [8:0] v;
                v = {~(^d[7:0]), d[7:0]};
                line_q.delete();
                put(v);
                add_frame(v, 1'b1, par_odd, 1'b0);
                check_stream("R7 R6 parity frame");
            end
        end
        par_mode = 1'b0;
        par_odd  = 1'b0;

        // R8 R10 back-to-back with two stop bits
        two_stop = 1'b1;
        line_q.delete();
        put(9'h155);
        put(9'h0F0);
        add_frame(9'h155, 1'b0, 1'b0, 1'b1);
        add_frame(9'h0F0, 1'b0, 1'b0, 1'b1);
        add_idle(3);
        check_stream("R8 R10 two stop chain");
        two_stop = 1'b0;

        // R2 R4 R11 fill in queue mode, drop on full
        fifo_on = 1'b1;
        line_q.delete();
        put(9'h011);
        repeat (3) @(posedge clk); #4;
        status("R4 queue count0", 1'b0, 1'b1, 1'b1);
        put(9'h122);
        status("R4 queue count1", 1'b0, 1'b1, 1'b0);
        put(9'h033);
        status("R4 queue count2", 1'b0, 1'b1, 1'b0);
        put(9'h144);
        status("R4 queue count3", 1'b0, 1'b0, 1'b0);
        put(9'h055);
        status("R2 queue full at depth", 1'b1, 1'b0, 1'b0);
        put(9'h1EE);
        status("R2 write while full", 1'b1, 1'b0, 1'b0);
        add_frame(9'h011, 1'b0, 1'b0, 1'b0);
        add_frame(9'h122, 1'b0, 1'b0, 1'b0);
        add_frame(9'h033, 1'b0, 1'b0, 1'b0);
        add_frame(9'h144, 1'b0, 1'b0, 1'b0);
        add_frame(9'h055, 1'b0, 1'b0, 1'b0);
        add_idle(13);
        check_stream("R2 R11 R10 order, dropped write");

        // R3 R4 slot mode overwrite
        fifo_on = 1'b0;
        line_q.delete();
        put(9'h0A1);
        repeat (3) @(posedge clk); #4;
        status("R4 slot empty", 1'b0, 1'b1, 1'b1);
        put(9'h0B2);
        status("R3 slot full at one", 1'b1, 1'b0, 1'b0);
        put(9'h1C3);
        status("R3 overwrite keeps one", 1'b1, 1'b0, 1'b0);
        add_frame(9'h0A1, 1'b0, 1'b0, 1'b0);
        add_frame(9'h1C3, 1'b0, 1'b0, 1'b0);
        add_idle(13);
        check_stream("R3 overwritten char sent");

        // R5 clear discards queued characters
        fifo_on = 1'b1;
        line_q.delete();
        put(9'h066);
        repeat (3) @(posedge clk); #4;
        put(9'h177);
        put(9'h088);
        status("R5 before clear", 1'b0, 1'b1, 1'b0);
        @(posedge clk); #4;
        fifo_clr = 1'b1;
        @(posedge clk); #4;
        fifo_clr = 1'b0;
        status("R5 after clear", 1'b0, 1'b1, 1'b1);
        add_frame(9'h066, 1'b0, 1'b0, 1'b0);
        add_idle(24);
        check_stream("R5 cleared chars not sent");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule